// File: doc/BRIEF.md
# Stack Address Arithmetic Register Slice

This block is one slice of an address unit for stacks and program counters kept in RAM. It holds three pointer registers: R0 is the program counter, R1 the stack pointer and R2 the operand address. A 4-bit code picks one of sixteen operations, and each one finishes in a single clock. The operations are increment, decrement, load from the data input, transfer between registers, relative add of the data input, no-operation and clear-all. The slice is `W` bits wide, 4 by default. A carry/borrow input and output let several slices be chained: for example, four slices give a 16-bit address.

Two address ports show one register picked by a select input. The transparent port is combinational. In post mode it shows the register's present value. In pre mode it shows the value the register will take at the coming edge, so a pre-decremented stack pointer can address RAM in the same cycle. The registered port captures at each edge the value the transparent port showed during that cycle. Each port has its own active-low enable. When the enable is high the port is released to high impedance.

Top module: `sar_slice`

## Requirements
- R1: A synchronous active-high reset clears R0, R1, R2 and the registered port to zero at the clock edge.
- R2: Codes 0, 1 and 2 add the carry input to R0, R1 and R2 modulo 2^W. The carry output is 1 exactly when that sum wraps past all-ones.
- R3: Codes 3, 4 and 5 subtract the carry input from R0, R1 and R2 modulo 2^W. The carry output acts as a borrow: it is 1 exactly when the register is zero and the carry input is 1.
- R4: Codes 6, 7 and 8 load the data input into R0, R1 and R2 respectively.
- R5: Code 9 copies R0 into R2. Code 10 copies R2 into R0. Code 11 copies R1 into R2.
- R6: Code 12 sets R2 to R2 + data + carry-in, and code 13 does the same for R0, both modulo 2^W. The carry output is the carry out of that sum.
- R7: Code 14 leaves all three registers unchanged. Code 15 clears all three.
- R8: The carry output is 0 for every code other than 0–5, 12 and 13, whatever the carry input.
- R9: Select values 0, 1 and 2 choose R0, R1 and R2 for the ports, and select value 3 drives zero. The transparent port shows the selected register's current value when the pre-select input is 0. When pre-select is 1, it shows the value that register takes at the next edge, within the same cycle.
- R10: At each clock edge outside reset, the registered port takes the value the transparent port showed in the cycle before the edge.
- R11: Driving an output enable high releases its port to high impedance. Driving it low drives the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Operation code |
| din | input | W | Data input for loads and relative adds |
| cin | input | 1 | Carry/borrow in from the less significant slice |
| pre_sel | input | 1 | 1: ports show the updated value; 0: the value before the update |
| rsel | input | 2 | Register shown on the ports (3 = zero) |
| oe_q_n | input | 1 | Active-low enable of the registered port |
| oe_t_n | input | 1 | Active-low enable of the transparent port |
| addr_q | output | W | Registered address port (tri-state) |
| addr_t | output | W | Transparent address port (tri-state) |
| cout | output | 1 | Carry/borrow out to the next slice |

## Verification
The checker watches every cycle for the following properties:
- the registered port lags the transparent view by one edge;
- in pre mode, the selected register ends up at the value that was shown;
- no-operation holds all three registers, and clear-all zeroes them;
- loads of R0 store the data input;
- the carry output stays quiet outside the arithmetic codes;
- reset clears the registers.

Only the bench scenarios can show the arithmetic values themselves. These include wrap and borrow at the register boundaries, the order of each transfer, the select-3 zero, and the high-impedance release of each port under its enable.

// File: rtl/sar_pkg.sv
package sar_pkg;

   localparam int NREG = 3;
   localparam int NSEL = 4;

   typedef enum logic [1:0] {
      ALU_PASS = 2'd0,
      ALU_INC  = 2'd1,
      ALU_DEC  = 2'd2,
      ALU_ADD  = 2'd3
   } alu_fn_e;

   typedef enum logic [1:0] {
      SRC_ALU  = 2'd0,
      SRC_DIN  = 2'd1,
      SRC_XFER = 2'd2
   } src_e;

   typedef struct packed {
      logic       wr;
      logic       clr;
      logic [1:0] dst;
      logic [1:0] xsrc;
      src_e       src;
      alu_fn_e    fn;
   } ctl_t;

endpackage

// File: rtl/sar_decode.sv
module sar_decode
   import sar_pkg::*;
(
   input  logic [3:0] op,
   output ctl_t       ctl
);

   always_comb begin
      ctl      = '0;
      ctl.src  = SRC_ALU;
      ctl.fn   = ALU_PASS;
      case (op)
         4'd0, 4'd1, 4'd2: begin
            ctl.wr  = 1'b1;
            ctl.dst = op[1:0];
            ctl.fn  = ALU_INC;
         end
         4'd3, 4'd4, 4'd5: begin
            ctl.wr  = 1'b1;
            ctl.dst = 2'(op - 4'd3);
            ctl.fn  = ALU_DEC;
         end
         4'd6, 4'd7, 4'd8: begin
            ctl.wr  = 1'b1;
            ctl.dst = 2'(op - 4'd6);
            ctl.src = SRC_DIN;
         end
         4'd9: begin
            ctl.wr   = 1'b1;
            ctl.dst  = 2'd2;
            ctl.xsrc = 2'd0;
            ctl.src  = SRC_XFER;
         end
         4'd10: begin
            ctl.wr   = 1'b1;
            ctl.dst  = 2'd0;
            ctl.xsrc = 2'd2;
            ctl.src  = SRC_XFER;
         end
         4'd11: begin
            ctl.wr   = 1'b1;
            ctl.dst  = 2'd2;
            ctl.xsrc = 2'd1;
            ctl.src  = SRC_XFER;
         end
         4'd12: begin
            ctl.wr  = 1'b1;
            ctl.dst = 2'd2;
            ctl.fn  = ALU_ADD;
         end
         4'd13: begin
            ctl.wr  = 1'b1;
            ctl.dst = 2'd0;
            ctl.fn  = ALU_ADD;
         end
         4'd15: begin
            ctl.clr = 1'b1;
         end
         default: begin
            ctl.wr = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/sar_alu.sv
module sar_alu
   import sar_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  alu_fn_e      fn,
   output logic [W-1:0] y,
   output logic         cout
);

   localparam int WE = W + 1;

   logic [WE-1:0] sum;
   logic [WE-1:0] a_x;
   logic [WE-1:0] b_x;
   logic [WE-1:0] c_x;

   assign a_x = {1'b0, a};
   assign b_x = {1'b0, b};
   assign c_x = {{W{1'b0}}, cin};

   always_comb begin
      case (fn)
         ALU_INC: sum = a_x + c_x;
         ALU_DEC: sum = a_x - c_x;
         ALU_ADD: sum = a_x + b_x + c_x;
         default: sum = a_x;
      endcase
   end

   assign y    = sum[W-1:0];
   assign cout = (fn == ALU_PASS) ? 1'b0 : sum[W];

endmodule

// File: rtl/sar_regfile.sv
module sar_regfile
   import sar_pkg::*;
#(
   parameter int W = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      wr,
   input  logic                      clr,
   input  logic [1:0]                dst,
   input  logic [W-1:0]              wdata,
   output logic [NREG-1:0][W-1:0]    q,
   output logic [NREG-1:0][W-1:0]    nxt
);

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_comb begin
         if (clr)
            nxt[g] = '0;
         else if (wr && (dst == 2'(g)))
            nxt[g] = wdata;
         else
            nxt[g] = q[g];
      end

      always_ff @(posedge clk) begin
         if (rst)
            q[g] <= '0;
         else
            q[g] <= nxt[g];
      end
   end

endmodule

// File: rtl/sar_slice.sv
module sar_slice
   import sar_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [3:0]   op,
   input  logic [W-1:0] din,
   input  logic         cin,
   input  logic         pre_sel,
   input  logic [1:0]   rsel,
   input  logic         oe_q_n,
   input  logic         oe_t_n,
   output logic [W-1:0] addr_q,
   output logic [W-1:0] addr_t,
   output logic         cout
);

   if (W < 1 || W > 32) begin : g_bad_width
      $error("sar_slice: W must lie in 1..32");
   end
   if (NSEL != NREG + 1) begin : g_bad_sel
      $error("sar_slice: select space must be register count plus one");
   end

   ctl_t                    ctl;
   logic [NREG-1:0][W-1:0]  regs_q;
   logic [NREG-1:0][W-1:0]  regs_nxt;
   logic [NSEL-1:0][W-1:0]  q4;
   logic [NSEL-1:0][W-1:0]  n4;
   logic [W-1:0]            alu_y;
   logic [W-1:0]            wdata;
   logic [W-1:0]            view;
   logic [W-1:0]            addr_q_r;

   sar_decode u_dec (
      .op  (op),
      .ctl (ctl)
   );

   assign q4 = {{W{1'b0}}, regs_q};
   assign n4 = {{W{1'b0}}, regs_nxt};

   sar_alu #(.W(W)) u_alu (
      .a    (q4[ctl.dst]),
      .b    (din),
      .cin  (cin),
      .fn   (ctl.fn),
      .y    (alu_y),
      .cout (cout)
   );

   always_comb begin
      case (ctl.src)
         SRC_DIN:  wdata = din;
         SRC_XFER: wdata = q4[ctl.xsrc];
         default:  wdata = alu_y;
      endcase
   end

   sar_regfile #(.W(W)) u_rf (
      .clk   (clk),
      .rst   (rst),
      .wr    (ctl.wr),
      .clr   (ctl.clr),
      .dst   (ctl.dst),
      .wdata (wdata),
      .q     (regs_q),
      .nxt   (regs_nxt)
   );

   assign view = pre_sel ? n4[rsel] : q4[rsel];

   always_ff @(posedge clk) begin
      if (rst)
         addr_q_r <= '0;
      else
         addr_q_r <= view;
   end

   assign addr_t = oe_t_n ? {W{1'bz}} : view;
   assign addr_q = oe_q_n ? {W{1'bz}} : addr_q_r;

endmodule

// File: rtl/sar_slice_chk.sv
module sar_slice_chk #(
   parameter int W = 4
) (
   input logic                clk,
   input logic                rst,
   input logic [3:0]          op,
   input logic [W-1:0]        din,
   input logic                pre_sel,
   input logic [1:0]          rsel,
   input logic                cout,
   input logic [3:0][W-1:0]   regs4,
   input logic [W-1:0]        view,
   input logic [W-1:0]        port_q
);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (regs4 == '0 && port_q == '0));                                  // R1

   AST_PORT_LAG: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (port_q == $past(view)));                                       // R10

   AST_PRE_LANDS: assert property (@(posedge clk) disable iff (rst)
      (pre_sel && rsel != 2'd3) |=> (regs4[$past(rsel)] == $past(view)));      // R9

   AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (op == 4'd14) |=> $stable(regs4));                                       // R7

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
      (op == 4'd15) |=> (regs4 == '0));                                        // R7

   AST_LOAD_R0: assert property (@(posedge clk) disable iff (rst)
      (op == 4'd6) |=> (regs4[0] == $past(din)));                              // R4

   AST_COUT_ARITH_ONLY: assert property (@(posedge clk) disable iff (rst)
      cout |-> (op <= 4'd5 || op == 4'd12 || op == 4'd13));                    // R8

endmodule

bind sar_slice sar_slice_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .op      (op),
   .din     (din),
   .pre_sel (pre_sel),
   .rsel    (rsel),
   .cout    (cout),
   .regs4   ({{W{1'b0}}, regs_q}),
   .view    (view),
   .port_q  (addr_q_r)
);

// File: tb/sar_slice_bench.sv
`timescale 1ns/1ps
module sar_slice_bench;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst;
   logic [3:0]   op;
   logic [W-1:0] din;
   logic         cin;
   logic         pre_sel;
   logic [1:0]   rsel;
   logic         oe_q_n;
   logic         oe_t_n;
   logic         cout;
   wire  [W-1:0] addr_q_w;
   wire  [W-1:0] addr_t_w;
   logic         drv_q_en;
   logic         drv_t_en;
   logic [W-1:0] drv_val;

   assign addr_q_w = drv_q_en ? drv_val : {W{1'bz}};
   assign addr_t_w = drv_t_en ? drv_val : {W{1'bz}};

   always #2 clk = ~clk;

   sar_slice #(.W(W)) u_sar_slice (
      .clk     (clk),
      .rst     (rst),
      .op      (op),
      .din     (din),
      .cin     (cin),
      .pre_sel (pre_sel),
      .rsel    (rsel),
      .oe_q_n  (oe_q_n),
      .oe_t_n  (oe_t_n),
      .addr_q  (addr_q_w),
      .addr_t  (addr_t_w),
      .cout    (cout)
   );

   typedef struct {
      logic [W-1:0] t;
      logic         c;
      string        tag;
   } exp_item_t;

   exp_item_t    sbq[$];
   logic [W-1:0] m [3];
   int           n_chk  = 0;
   int           n_fail = 0;
   bit           done   = 1'b0;

   task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(logic [3:0] o, logic [W-1:0] d, logic ci, logic pre,
                       logic [1:0] rs, string tag);
      logic [W-1:0] nx [3];
      logic [W:0]   s;
      logic         c;
      exp_item_t    e;
      @(negedge clk);
      op = o; din = d; cin = ci; pre_sel = pre; rsel = rs;
      for (int i = 0; i < 3; i++) nx[i] = m[i];
      c = 1'b0;
      case (o)
         4'd0, 4'd1, 4'd2: begin
            s = {1'b0, m[o]} + (W+1)'(ci);
            nx[o] = s[W-1:0]; c = s[W];
         end
         4'd3, 4'd4, 4'd5: begin
            s = {1'b0, m[o-3]} - (W+1)'(ci);
            nx[o-3] = s[W-1:0]; c = s[W];
         end
         4'd6, 4'd7, 4'd8: nx[o-6] = d;
         4'd9:  nx[2] = m[0];
         4'd10: nx[0] = m[2];
         4'd11: nx[2] = m[1];
         4'd12: begin
            s = {1'b0, m[2]} + {1'b0, d} + (W+1)'(ci);
            nx[2] = s[W-1:0]; c = s[W];
         end
         4'd13: begin
            s = {1'b0, m[0]} + {1'b0, d} + (W+1)'(ci);
            nx[0] = s[W-1:0]; c = s[W];
         end
         4'd15: for (int i = 0; i < 3; i++) nx[i] = '0;
         default: ;
      endcase
      if (rs == 2'd3) e.t = '0;
      else            e.t = pre ? nx[rs] : m[rs];
      e.c   = c;
      e.tag = tag;
      sbq.push_back(e);
      for (int i = 0; i < 3; i++) m[i] = nx[i];
   endtask

   task automatic idle(int n);
      @(negedge clk);
      op = 4'd14; cin = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin : monitor
      exp_item_t e;
      forever begin
         @(negedge clk);
         #1;
         if (sbq.size() > 0) begin
            e = sbq.pop_front();
            check({e.tag, " transparent"}, addr_t_w, e.t);
            check({e.tag, " cout"}, W'(cout), W'(e.c));
            @(posedge clk);
            #1;
            check({"R10 registered after ", e.tag}, addr_q_w, e.t);
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : driver
      rst = 1'b1; op = 4'd14; din = '0; cin = 1'b0; pre_sel = 1'b0; rsel = 2'd0;
      oe_q_n = 1'b0; oe_t_n = 1'b0; drv_q_en = 1'b0; drv_t_en = 1'b0; drv_val = '0;
      for (int i = 0; i < 3; i++) m[i] = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int r = 0; r < 3; r++) begin
         rsel = 2'(r);
         #0.2;
         check("R1 reset register view", addr_t_w, '0);
      end
      check("R1 reset registered port", addr_q_w, '0);

      // R4 loads in both modes
      step(4'd6, 4'h5, 1'b0, 1'b1, 2'd0, "R4 load R0 pre");
      step(4'd7, 4'h9, 1'b1, 1'b0, 2'd1, "R4 load R1 post");
      step(4'd8, 4'hF, 1'b0, 1'b1, 2'd2, "R4 load R2 pre");
      // R2 increments incl. wrap and cin=0
      step(4'd0, 4'h0, 1'b1, 1'b0, 2'd0, "R2 inc R0 post");
      step(4'd2, 4'h0, 1'b1, 1'b1, 2'd2, "R2 inc R2 wrap");
      step(4'd1, 4'h0, 1'b0, 1'b1, 2'd1, "R2 inc R1 cin0");
      step(4'd1, 4'h0, 1'b1, 1'b1, 2'd1, "R2 inc R1");
      // R3 decrements incl. borrow
      step(4'd4, 4'h0, 1'b1, 1'b1, 2'd1, "R3 dec R1");
      step(4'd5, 4'h0, 1'b1, 1'b0, 2'd2, "R3 dec R2 borrow post");
      step(4'd5, 4'h0, 1'b1, 1'b1, 2'd2, "R3 dec R2 pre");
      step(4'd3, 4'h0, 1'b0, 1'b1, 2'd0, "R3 dec R0 cin0");
      // R5 transfers
      step(4'd9,  4'h0, 1'b1, 1'b1, 2'd2, "R5 R0 to R2");
      step(4'd8,  4'h3, 1'b0, 1'b1, 2'd2, "R4 load R2");
      step(4'd10, 4'h0, 1'b1, 1'b1, 2'd0, "R5 R2 to R0");
      step(4'd11, 4'h0, 1'b1, 1'b1, 2'd2, "R5 R1 to R2");
      // R6 relative adds
      step(4'd12, 4'h9, 1'b1, 1'b1, 2'd2, "R6 add R2 carry");
      step(4'd13, 4'h4, 1'b0, 1'b1, 2'd0, "R6 add R0");
      step(4'd13, 4'hD, 1'b0, 1'b0, 2'd0, "R6 add R0 post");
      // R7, R8, R9
      step(4'd14, 4'h7, 1'b1, 1'b1, 2'd1, "R7 nop holds R1");
      step(4'd7,  4'hE, 1'b1, 1'b1, 2'd1, "R8 load ignores cin");
      step(4'd14, 4'h0, 1'b0, 1'b1, 2'd3, "R9 select 3 zero");
      step(4'd15, 4'h0, 1'b1, 1'b1, 2'd0, "R7 clear pre");
      step(4'd14, 4'h0, 1'b0, 1'b0, 2'd1, "R7 R1 cleared");
      step(4'd14, 4'h0, 1'b0, 1'b0, 2'd2, "R7 R2 cleared");
      idle(3);

      // R11 enables: released port reads the bench's own driver
      step(4'd6, 4'hA, 1'b0, 1'b0, 2'd0, "R4 load R0 again");
      idle(3);
      oe_t_n = 1'b1; drv_t_en = 1'b1; drv_val = 4'h5;
      #1;
      check("R11 transparent released", addr_t_w, 4'h5);
      drv_t_en = 1'b0; oe_t_n = 1'b0;
      #0.5;
      check("R11 transparent driven", addr_t_w, 4'hA);
      oe_q_n = 1'b1; drv_q_en = 1'b1; drv_val = 4'h3;
      #0.5;
      check("R11 registered released", addr_q_w, 4'h3);
      drv_q_en = 1'b0; oe_q_n = 1'b0;
      #0.5;
      check("R11 registered driven", addr_q_w, 4'hA);

      // R1 reset mid-run
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0; pre_sel = 1'b0; rsel = 2'd0;
      #0.5;
      check("R1 reset clears R0", addr_t_w, '0);
      check("R1 reset clears registered port", addr_q_w, '0);

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule